// File: doc/BRIEF.md
# Five-Level Phase-Disposition PWM Modulator with Redundant-State Balancing

This block turns a signed modulating reference into the eight gate signals of a single-phase, five-level, neutral-point-clamped bridge. One up/down counter forms a triangular carrier. Four copies of that carrier are offset into equal, stacked bands spanning the full reference range, and all four move in phase. Each cycle the block counts how many of these carriers lie below the held reference. That count gives the output level: full positive bus, positive half bus, zero, negative half bus, or full negative bus.

Each half-bus level can be produced by two redundant switch patterns. Each pattern charges or discharges only one of the two split DC-link capacitors. The block picks the pattern from three inputs: a balancing enable, the sign of the upper-minus-lower capacitor voltage difference, and the sign of the bridge output current. It samples the reference and these inputs once per switching period, at the carrier trough, and holds them for the whole period. Before the gate pins, a programmable dead time delays every rising gate edge and lets falling edges through at once.

With the default parameters and a 50 MHz clock, the switching period is 10000 cycles (5 kHz). In a converter, a current controller writes the reference once per control step. Sign comparators on the capacitor-voltage and current measurements supply the two sign bits.

Top module: `flvl_modulator`

## Requirements
- R1: A phase counter runs from 0 to 2H-1 and wraps, where H is HALF_PERIOD. The carrier equals the phase for phase <= H and 2H - phase above H. Carrier k (k = 0..3) is -2H + k*H + carrier.
- R2: The reference is taken as a signed 16-bit value and saturated to the range [-2H, +2H] before it is held.
- R3: The level count n is the number of carriers strictly below the held reference. The gate vector (bit i is gate i) is 0x23 for n = 4, 0xC6 for n = 2 and 0x1C for n = 0.
- R4: For n = 3, the gate vector is 0x66 when the held enable is 1, the held difference-sign bit is 0 and the held current-sign bit is 0 (a sign bit of 1 means negative). Otherwise it is 0x53.
- R5: For n = 1, the gate vector is 0x96 when the held enable is 1 and both held sign bits are 1. Otherwise it is 0x9C.
- R6: The reference, enable and both sign bits are captured only on the clock edge where the phase wraps to 0. Changes at any other time have no effect until the next wrap.
- R7: While the held enable is 0, gate bits 7 and 6 are forced to 1 at every level.
- R8: After reset the phase is 0 and all gates are 0 until the first wrap. The held reference is 0.
- R9: A gate rises only after its request has been high for deadCycles consecutive cycles. It falls in the same cycle its request falls. With deadCycles = 0 the gates follow the request.
- R10: Gate bit 6 is on at both positive half-bus patterns, bit 7 is on at both negative half-bus patterns, and both are on at the zero level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 16 | Signed modulating reference |
| balEn | input | 1 | Capacitor balancing enable |
| capDiffNeg | input | 1 | 1 when the upper capacitor voltage is below the lower |
| curNeg | input | 1 | 1 when the bridge output current is negative |
| deadCycles | input | DT_W | Rising-edge delay in clock cycles |
| gateOut | output | 8 | Gate drive signals, bit i drives switch i |

## Verification
The bench builds the block with HALF_PERIOD = 8 and DT_W = 4, which gives a 16-cycle switching period. With that setting, a sweep of references from -19 to +19 crosses every carrier threshold at every phase and passes both saturation limits. Each reference is run with all eight combinations of enable and the two sign bits. Mid-period, every input is flipped to show that the held selection does not move. The sweep runs once with no dead time and once with a dead time of 3. In the second run, short level pulses of one or two cycles must be swallowed completely while long ones are only delayed.

// File: rtl/flvl_pkg.sv
package flvl_pkg;

  localparam int NUM_CARRIERS = 4;
  localparam int GATE_N       = 8;

  typedef enum logic [2:0] {
    ST_POS_FULL    = 3'd0,
    ST_POS_HALF_UP = 3'd1,
    ST_POS_HALF_LO = 3'd2,
    ST_ZERO        = 3'd3,
    ST_NEG_HALF_UP = 3'd4,
    ST_NEG_HALF_LO = 3'd5,
    ST_NEG_FULL    = 3'd6
  } bridgeState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latch;    // last cycle of the period: capture inputs
    logic armed;    // first period boundary has passed
    logic countUp;  // carrier rising half
  } ctrlStrobe_t;

  localparam logic [GATE_N-1:0] PAT_POS_FULL    = 8'h23;
  localparam logic [GATE_N-1:0] PAT_POS_HALF_UP = 8'h66;
  localparam logic [GATE_N-1:0] PAT_POS_HALF_LO = 8'h53;
  localparam logic [GATE_N-1:0] PAT_ZERO        = 8'hC6;
  localparam logic [GATE_N-1:0] PAT_NEG_HALF_UP = 8'h9C;
  localparam logic [GATE_N-1:0] PAT_NEG_HALF_LO = 8'h96;
  localparam logic [GATE_N-1:0] PAT_NEG_FULL    = 8'h1C;

  function automatic logic [GATE_N-1:0] gatePattern(bridgeState_e st);
    logic [GATE_N-1:0] pat;
    case (st)
      ST_POS_FULL:    pat = PAT_POS_FULL;
      ST_POS_HALF_UP: pat = PAT_POS_HALF_UP;
      ST_POS_HALF_LO: pat = PAT_POS_HALF_LO;
      ST_ZERO:        pat = PAT_ZERO;
      ST_NEG_HALF_UP: pat = PAT_NEG_HALF_UP;
      ST_NEG_HALF_LO: pat = PAT_NEG_HALF_LO;
      ST_NEG_FULL:    pat = PAT_NEG_FULL;
      default:        pat = '0;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/flvl_ctrl.sv
module flvl_ctrl
  import flvl_pkg::*;
#(
  parameter int HALF_PERIOD = 5000,
  localparam int PH_W = $clog2(2 * HALF_PERIOD)
) (
  input  logic            clk,
  input  logic            rstN,
  output ctrlStrobe_t     strobe,
  output logic [PH_W-1:0] phase
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_PERIOD - 1);
  localparam logic [PH_W-1:0] PH_PEAK = PH_W'(HALF_PERIOD);

  logic armedQ;
  logic atLast;

  assign atLast = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      armedQ <= 1'b0;
    end else begin
      phase <= atLast ? '0 : phase + 1'b1;
      if (atLast) armedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.latch   = atLast;
    strobe.armed   = armedQ;
    strobe.countUp = (phase < PH_PEAK);
  end

endmodule

// File: rtl/flvl_datapath.sv
module flvl_datapath
  import flvl_pkg::*;
#(
  parameter int HALF_PERIOD = 5000,
  parameter int REF_W       = 16,
  localparam int CAR_W = $clog2(HALF_PERIOD + 1),
  localparam int CMP_W = REF_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic signed [REF_W-1:0] refIn,
  input  logic                    balEn,
  input  logic                    capDiffNeg,
  input  logic                    curNeg,
  output logic [CAR_W-1:0]        carrier,
  output logic signed [REF_W-1:0] refHeld,
  output logic                    enHeld,
  output logic                    dnHeld,
  output logic                    inHeld,
  output logic [2:0]              levelCount,
  output logic [GATE_N-1:0]       rawGates
);

  localparam logic signed [CMP_W-1:0] LIM_HI = CMP_W'(2 * HALF_PERIOD);
  localparam logic signed [CMP_W-1:0] LIM_LO = -LIM_HI;

  // triangular carrier driven by control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               carrier <= '0;
    else if (strobe.countUp) carrier <= carrier + 1'b1;
    else                     carrier <= carrier - 1'b1;
  end

  // reference saturation
  logic signed [CMP_W-1:0] refWide;
  logic signed [CMP_W-1:0] refClamp;

  assign refWide = {{2{refIn[REF_W-1]}}, refIn};

  always_comb begin
    if (refWide > LIM_HI)      refClamp = LIM_HI;
    else if (refWide < LIM_LO) refClamp = LIM_LO;
    else                       refClamp = refWide;
  end

  // once-per-period capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refHeld <= '0;
      enHeld  <= 1'b0;
      dnHeld  <= 1'b0;
      inHeld  <= 1'b0;
    end else if (strobe.latch) begin
      refHeld <= refClamp[REF_W-1:0];
      enHeld  <= balEn;
      dnHeld  <= capDiffNeg;
      inHeld  <= curNeg;
    end
  end

  // level-shifted comparisons
  logic signed [CMP_W-1:0] refHeldWide;
  logic signed [CMP_W-1:0] carrierWide;
  logic [NUM_CARRIERS-1:0] above;

  assign refHeldWide = {{2{refHeld[REF_W-1]}}, refHeld};
  assign carrierWide = $signed({{(CMP_W - CAR_W){1'b0}}, carrier});

  for (genvar k = 0; k < NUM_CARRIERS; k++) begin : gBand
    localparam logic signed [CMP_W-1:0] BAND_BASE = CMP_W'(k * HALF_PERIOD) - LIM_HI;
    logic signed [CMP_W-1:0] bandCarrier;
    assign bandCarrier = BAND_BASE + carrierWide;
    assign above[k]    = (refHeldWide > bandCarrier);
  end

  always_comb begin
    levelCount = '0;
    for (int k = 0; k < NUM_CARRIERS; k++) begin
      levelCount = levelCount + {2'b00, above[k]};
    end
  end

  // level and redundant-state selection
  bridgeState_e bridgeState;
  logic pickPosUpper;
  logic pickNegLower;

  assign pickPosUpper = enHeld && !dnHeld && !inHeld;
  assign pickNegLower = enHeld &&  dnHeld &&  inHeld;

  always_comb begin
    case (levelCount)
      3'd4:    bridgeState = ST_POS_FULL;
      3'd3:    bridgeState = pickPosUpper ? ST_POS_HALF_UP : ST_POS_HALF_LO;
      3'd2:    bridgeState = ST_ZERO;
      3'd1:    bridgeState = pickNegLower ? ST_NEG_HALF_LO : ST_NEG_HALF_UP;
      default: bridgeState = ST_NEG_FULL;
    endcase
  end

  always_comb begin
    rawGates = '0;
    if (strobe.armed) begin
      rawGates = gatePattern(bridgeState);
      if (!enHeld) rawGates[7:6] = 2'b11;
    end
  end

endmodule

// File: rtl/flvl_deadband.sv
module flvl_deadband #(
  parameter int LANES = 8,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DT_W-1:0]  deadCycles,
  input  logic [LANES-1:0] rawGates,
  output logic [LANES-1:0] gateOut
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DT_W-1:0] holdCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     holdCnt <= '0;
      else if (!rawGates[g])         holdCnt <= '0;
      else if (holdCnt < deadCycles) holdCnt <= holdCnt + 1'b1;
    end

    // rising edge waits for the count, falling edge is immediate
    assign gateOut[g] = rawGates[g] && (holdCnt >= deadCycles);
  end

endmodule

// File: rtl/flvl_modulator.sv
module flvl_modulator
  import flvl_pkg::*;
#(
  parameter int HALF_PERIOD = 5000,
  parameter int REF_W       = 16,
  parameter int DT_W        = 8,
  localparam int PH_W  = $clog2(2 * HALF_PERIOD),
  localparam int CAR_W = $clog2(HALF_PERIOD + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refIn,
  input  logic                    balEn,
  input  logic                    capDiffNeg,
  input  logic                    curNeg,
  input  logic [DT_W-1:0]         deadCycles,
  output logic [GATE_N-1:0]       gateOut
);

  ctrlStrobe_t             strobe;
  logic [PH_W-1:0]         phase;
  logic [CAR_W-1:0]        carrier;
  logic signed [REF_W-1:0] refHeld;
  logic                    enHeld;
  logic                    dnHeld;
  logic                    inHeld;
  logic [2:0]              levelCount;
  logic [GATE_N-1:0]       rawGates;

  flvl_ctrl #(.HALF_PERIOD(HALF_PERIOD)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .phase (phase)
  );

  flvl_datapath #(.HALF_PERIOD(HALF_PERIOD), .REF_W(REF_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .refIn     (refIn),
    .balEn     (balEn),
    .capDiffNeg(capDiffNeg),
    .curNeg    (curNeg),
    .carrier   (carrier),
    .refHeld   (refHeld),
    .enHeld    (enHeld),
    .dnHeld    (dnHeld),
    .inHeld    (inHeld),
    .levelCount(levelCount),
    .rawGates  (rawGates)
  );

  flvl_deadband #(.LANES(GATE_N), .DT_W(DT_W)) uDead (
    .clk       (clk),
    .rstN      (rstN),
    .deadCycles(deadCycles),
    .rawGates  (rawGates),
    .gateOut   (gateOut)
  );

endmodule

// File: rtl/flvl_modulator_chk.sv
module flvl_modulator_chk
  import flvl_pkg::*;
#(
  parameter int HALF_PERIOD = 5000,
  parameter int REF_W       = 16,
  parameter int DT_W        = 8,
  localparam int PH_W  = $clog2(2 * HALF_PERIOD),
  localparam int CAR_W = $clog2(HALF_PERIOD + 1)
) (
  input logic                    clk,
  input logic                    rstN,
  input ctrlStrobe_t             strobe,
  input logic [PH_W-1:0]         phase,
  input logic [CAR_W-1:0]        carrier,
  input logic signed [REF_W-1:0] refHeld,
  input logic                    enHeld,
  input logic                    dnHeld,
  input logic                    inHeld,
  input logic [2:0]              levelCount,
  input logic [GATE_N-1:0]       rawGates,
  input logic [DT_W-1:0]         deadCycles,
  input logic [GATE_N-1:0]       gateOut
);

  localparam logic [PH_W:0] FULL_P = (PH_W + 1)'(2 * HALF_PERIOD);
  localparam int signed LIM = 2 * HALF_PERIOD;

  logic [PH_W:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst < FULL_P) sinceRst <= sinceRst + 1'b1;
  end

  // R1
  carrier_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    carrier <= CAR_W'(HALF_PERIOD));

  // R1
  carrier_trough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == '0) == (carrier == '0));

  // R1
  carrier_slope_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countUp |=> carrier == $past(carrier) + 1'b1);

  // R2
  ref_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(refHeld) <= LIM) && (int'(refHeld) >= -LIM));

  // R3
  full_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && levelCount == 3'd4) |-> rawGates[5:0] == 6'h23);

  // R4
  pos_half_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && levelCount == 3'd3) |->
      rawGates == ((enHeld && !dnHeld && !inHeld) ? 8'h66 : (enHeld ? 8'h53 : 8'hD3)));

  // R5
  neg_half_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && levelCount == 3'd1) |->
      rawGates == ((enHeld && dnHeld && inHeld) ? 8'h96 : (enHeld ? 8'h9C : 8'hDC)));

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(refHeld) && $stable({enHeld, dnHeld, inHeld}));

  // R7
  neutral_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && !enHeld) |-> rawGates[7:6] == 2'b11);

  // R8
  gates_held_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < FULL_P) |-> gateOut == '0);

  // R9
  no_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deadCycles == '0) |-> gateOut == rawGates);

  for (genvar g = 0; g < GATE_N; g++) begin : gDt
    // R9
    delayed_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateOut[g]) && deadCycles != '0) |-> $past(rawGates[g]));
    // R9
    prompt_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rawGates[g]) |-> !gateOut[g]);
  end

  // R10
  neutral_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armed |->
      ((levelCount != 3'd3 || rawGates[6]) &&
       (levelCount != 3'd1 || rawGates[7]) &&
       (levelCount != 3'd2 || rawGates[7:6] == 2'b11)));

endmodule

bind flvl_modulator flvl_modulator_chk #(
  .HALF_PERIOD(HALF_PERIOD), .REF_W(REF_W), .DT_W(DT_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .strobe    (strobe),
  .phase     (phase),
  .carrier   (carrier),
  .refHeld   (refHeld),
  .enHeld    (enHeld),
  .dnHeld    (dnHeld),
  .inHeld    (inHeld),
  .levelCount(levelCount),
  .rawGates  (rawGates),
  .deadCycles(deadCycles),
  .gateOut   (gateOut)
);

// File: tb/flvl_modulator_test.sv
module flvl_modulator_test;

  localparam int H   = 8;
  localparam int P   = 2 * H;
  localparam int DTW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rstN;
  logic signed [15:0] refIn;
  logic               balEn;
  logic               capDiffNeg;
  logic               curNeg;
  logic [DTW-1:0]     deadCycles;
  logic [7:0]         gateOut;

  flvl_modulator #(.HALF_PERIOD(H), .REF_W(16), .DT_W(DTW)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .balEn     (balEn),
    .capDiffNeg(capDiffNeg),
    .curNeg    (curNeg),
    .deadCycles(deadCycles),
    .gateOut   (gateOut)
  );

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  int edges;
  int curDt;
  int mRef;
  bit mEn, mDn, mIn, mArmed, mSat;
  int runLen [8];

  function automatic int satRef(int r);
    if (r > 2 * H)  return 2 * H;
    if (r < -2 * H) return -2 * H;
    return r;
  endfunction

  // gate encodings from R3, R4, R5, R7
  function automatic logic [7:0] patternFor(int n, bit en, bit dn, bit in);
    logic [7:0] pat;
    case (n)
      4:       pat = 8'h23;
      3:       pat = (en && !dn && !in) ? 8'h66 : 8'h53;
      2:       pat = 8'hC6;
      1:       pat = (en && dn && in) ? 8'h96 : 8'h9C;
      default: pat = 8'h1C;
    endcase
    if (!en) pat[7:6] = 2'b11;
    return pat;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at edge %0d: actual=%h expected=%h", tag, edges, act, exp);
    end
  endtask

  task automatic stepCycle();
    int p, c, n;
    logic [7:0] raw, exp;
    string tag;
    @(posedge clk);
    edges++;
    p = edges % P;
    if (p == 0) begin
      // R6: capture at the wrap edge only
      mRef   = satRef(int'(refIn));
      mSat   = (int'(refIn) != mRef);
      mEn    = balEn;
      mDn    = capDiffNeg;
      mIn    = curNeg;
      mArmed = 1'b1;
    end
    @(negedge clk);
    c = (p <= H) ? p : P - p;   // R1
    n = 0;
    for (int k = 0; k < 4; k++) begin
      if (mRef > (-2 * H + k * H + c)) n++;
    end
    raw = mArmed ? patternFor(n, mEn, mDn, mIn) : 8'h00;
    for (int g = 0; g < 8; g++) begin
      if (raw[g]) runLen[g]++;
      else        runLen[g] = 0;
      exp[g] = raw[g] && ((runLen[g] - 1) >= curDt);   // R9
    end
    if (!mArmed)           tag = "R8";
    else if (exp != raw)   tag = "R9";
    else if (mSat)         tag = "R2";
    else if (n == 3)       tag = "R4 R10";
    else if (n == 1)       tag = "R5 R10";
    else if (!mEn)         tag = "R7";
    else                   tag = "R1 R3";
    if (p > H) tag = {tag, " R6"};
    check(tag, gateOut, exp);
  endtask

  task automatic applyReset(int dt);
    rstN       = 1'b0;
    refIn      = 16'sd0;
    balEn      = 1'b0;
    capDiffNeg = 1'b0;
    curNeg     = 1'b0;
    curDt      = dt;
    deadCycles = DTW'(dt);
    repeat (3) @(negedge clk);
    check("R8 reset", gateOut, 8'h00);
    rstN   = 1'b1;
    edges  = 0;
    mArmed = 1'b0;
    mRef   = 0;
    mSat   = 1'b0;
    foreach (runLen[g]) runLen[g] = 0;
    // R8: inputs demand a level, gates must stay off until the first wrap
    refIn = 16'(2 * H);
    balEn = 1'b1;
    for (int s = 0; s < P - 1; s++) stepCycle();
  endtask

  task automatic runPeriod(int r, bit en, bit dn, bit in);
    refIn      = 16'(r);
    balEn      = en;
    capDiffNeg = dn;
    curNeg     = in;
    for (int s = 0; s < P; s++) begin
      if (s == H) begin
        // R6: disturbance mid-period must not be taken
        refIn      = 16'(-r);
        balEn      = !en;
        capDiffNeg = !dn;
        curNeg     = !in;
      end
      stepCycle();
    end
  endtask

  initial begin
    foreach (runLen[g]) runLen[g] = 0;
    for (int pass = 0; pass < 2; pass++) begin
      applyReset(pass == 0 ? 0 : 3);
      for (int r = -2 * H - 3; r <= 2 * H + 3; r++) begin
        for (int sel = 0; sel < 8; sel++) begin
          runPeriod(r, sel[2], sel[1], sel[0]);
        end
      end
      // R2: extremes of the 16-bit range
      runPeriod(32767, 1'b1, 1'b0, 1'b0);
      runPeriod(-32768, 1'b1, 1'b1, 1'b1);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog R1..R10 run: actual=not finished expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule